// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the data side of a processor for one programmed address and raises a debug event when a matching access happens. Software programs two registers through a small register port. The first holds a word-aligned watch address. The second holds the qualifiers and the enable. Every data access arrives as a set of sideband signals: byte address, byte lanes touched within the word, access kind, privilege, security state and the result of the local exclusive monitor.

The block checks each presented access against the programmed address. An address mask can widen the compare. A per-byte select narrows it to some lanes of the word. The access is further filtered by kind, privilege and security state. It can optionally be linked to one of several context-ID breakpoint units, whose match flags come in as a vector. A store exclusive can only hit when it passes the exclusive monitor. The result is a registered, single-cycle hit pulse.

Control register layout (bit: meaning): 0 enable; 2:1 privilege filter; 4:3 kind filter; 8:5 byte select; 15:14 security filter; 19:16 linked unit index; 20 link enable; 28:24 address mask; every other bit is zero on read and ignores writes. Access kind codes on `acc_kind`: 0 load, 1 store, 2 swap, 3 load exclusive, 4 store exclusive; codes 5 to 7 never hit.

Top module: `wpt_unit`

## Requirements
- R1: After reset both registers read 0, and a control register with bit 0 clear never produces a hit.
- R2: Control bits 31:29, 23:21 and 13:9 read as 0 whatever was written; all other control bits read back as written.
- R3: The watch register (`reg_sel`=0) stores address bits 31:2 and reads bits 1:0 as 0; address bits 1:0 of an access take no part in the compare.
- R4: Bit k of byte select (control 8:5) enables byte offset k; an access hits only if `acc_lanes` & select is nonzero.
- R5: An address mask value N (control 28:24) excludes address bits N-1:0 from the compare; N of 0, 1 or 2 compares bits 31:2 exactly.
- R6: Kind filter (control 4:3) 01 accepts load, load exclusive and swap; 10 accepts store, store exclusive and swap; 11 accepts all five kinds.
- R7: A store exclusive hits only when `acc_excl_pass` is 1.
- R8: Privilege filter (control 2:1) 01 accepts only `acc_priv`=1, 10 only `acc_priv`=0, 11 both.
- R9: Security filter (control 15:14) 00 accepts both states, 01 only `acc_secure`=0, 10 only `acc_secure`=1.
- R10: With control bit 20 set, a hit also needs `ctx_hit[i]` where i is control 19:16; indices at or above NUM_CTX never hit.
- R11: Kind filter 00, privilege filter 00 or security filter 11 suppress every hit.
- R12: `wp_hit` rises on the clock edge that samples a qualifying access with `acc_valid`=1 and lasts one cycle unless the next access also hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects watch address, 1 selects control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_lanes | input | 4 | Byte lanes touched within the word |
| acc_kind | input | 3 | Access kind code |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_secure | input | 1 | 1 for a Secure access |
| acc_excl_pass | input | 1 | Store exclusive passed the local monitor |
| ctx_hit | input | NUM_CTX | Context-ID match flags of the breakpoint units |
| wp_hit | output | 1 | Registered watchpoint hit pulse |

## Verification
Every qualifier feeds a single AND that is registered once, so any corrupted control field or watch address shows up at `wp_hit` on the edge right after the first access that the field decides. A stuck register bit shows on `reg_rdata` at once. The sweeps cover every filter encoding against every access kind, privilege and security combination. They cover all lane and select pairs, every address bit against a range of masks, and every link index against every one-hot flag. A wrong decode therefore fails within the sweep that owns its field.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

   typedef enum logic [2:0] {
      KIND_LOAD  = 3'd0,
      KIND_STORE = 3'd1,
      KIND_SWAP  = 3'd2,
      KIND_LDEX  = 3'd3,
      KIND_STEX  = 3'd4
   } acc_kind_e;

   typedef struct packed {
      logic [4:0] mask;
      logic       link_en;
      logic [3:0] link_idx;
      logic [1:0] sec;
      logic [3:0] bsel;
      logic [1:0] kind;
      logic [1:0] priv;
      logic       en;
   } wpt_ctrl_t;

   localparam int CTRL_MASK_LSB = 24;
   localparam int CTRL_LINK_BIT = 20;
   localparam int CTRL_IDX_LSB  = 16;
   localparam int CTRL_SEC_LSB  = 14;
   localparam int CTRL_BSEL_LSB = 5;
   localparam int CTRL_KIND_LSB = 3;
   localparam int CTRL_PRIV_LSB = 1;

   function automatic logic [31:0] ctrl_pack(wpt_ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[CTRL_MASK_LSB +: 5] = c.mask;
      w[CTRL_LINK_BIT]      = c.link_en;
      w[CTRL_IDX_LSB +: 4]  = c.link_idx;
      w[CTRL_SEC_LSB +: 2]  = c.sec;
      w[CTRL_BSEL_LSB +: 4] = c.bsel;
      w[CTRL_KIND_LSB +: 2] = c.kind;
      w[CTRL_PRIV_LSB +: 2] = c.priv;
      w[0]                  = c.en;
      return w;
   endfunction

   function automatic wpt_ctrl_t ctrl_unpack(logic [31:0] w);
      wpt_ctrl_t c;
      c.mask     = w[CTRL_MASK_LSB +: 5];
      c.link_en  = w[CTRL_LINK_BIT];
      c.link_idx = w[CTRL_IDX_LSB +: 4];
      c.sec      = w[CTRL_SEC_LSB +: 2];
      c.bsel     = w[CTRL_BSEL_LSB +: 4];
      c.kind     = w[CTRL_KIND_LSB +: 2];
      c.priv     = w[CTRL_PRIV_LSB +: 2];
      c.en       = w[0];
      return c;
   endfunction

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
   import wpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [ADDR_W-1:0] watch_addr,
   output wpt_ctrl_t         ctrl
);

   localparam int STORE_W = ADDR_W - 2;

   logic [STORE_W-1:0] addr_q;
   wpt_ctrl_t          ctrl_q;
   logic [31:0]        addr_rd;
   logic               wdata_unused;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         ctrl_q <= '0;
      end else if (reg_wr) begin
         if (reg_sel) ctrl_q <= ctrl_unpack(reg_wdata);
         else         addr_q <= reg_wdata[ADDR_W-1:2];
      end
   end

   generate
      if (ADDR_W == 32) begin : g_full
         assign addr_rd      = {addr_q, 2'b00};
         assign wdata_unused = ^{reg_wdata[31:29], reg_wdata[23:21], reg_wdata[13:9]};
      end else begin : g_narrow
         assign addr_rd      = {{(32-ADDR_W){1'b0}}, addr_q, 2'b00};
         assign wdata_unused = ^{reg_wdata[31:29], reg_wdata[23:21], reg_wdata[13:9],
                                 reg_wdata[31:ADDR_W]};
      end
   endgenerate

   assign reg_rdata  = reg_sel ? ctrl_pack(ctrl_q) : addr_rd;
   assign watch_addr = {addr_q, 2'b00};
   assign ctrl       = ctrl_q;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (reg_rdata[31:29] == 3'b0 && reg_rdata[23:21] == 3'b0 && reg_rdata[13:9] == 5'b0)) // R2
      else $error("reserved control bits read nonzero");
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> reg_rdata[1:0] == 2'b00) // R3
      else $error("watch address low bits nonzero");

endmodule

// File: rtl/wpt_addr_match.sv
module wpt_addr_match #(
   parameter int ADDR_W = 32,
   parameter int MASK_W = 5
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] watch_addr,
   input  logic [MASK_W-1:0] mask,
   output logic              addr_ok
);

   localparam int CMP_W = ADDR_W - 2;

   logic [CMP_W-1:0] bit_ok;
   logic             low_unused;

   generate
      for (genvar i = 2; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i-2] = (i < int'(mask)) || (acc_addr[i] == watch_addr[i]);
      end
   endgenerate

   assign low_unused = ^{acc_addr[1:0], watch_addr[1:0]};
   assign addr_ok    = &bit_ok;

endmodule

// File: rtl/wpt_attr_match.sv
module wpt_attr_match
   import wpt_pkg::*;
#(
   parameter int NUM_CTX = 16
) (
   input  wpt_ctrl_t          ctrl,
   input  logic [3:0]         acc_lanes,
   input  logic [2:0]         acc_kind,
   input  logic               acc_priv,
   input  logic               acc_secure,
   input  logic               acc_excl_pass,
   input  logic [NUM_CTX-1:0] ctx_hit,
   output logic               attr_ok,
   output logic               link_flag
);

   localparam int IDX_SPAN = 16;

   logic [IDX_SPAN-1:0] ctx_pad;
   logic is_load, is_store, kind_ok, priv_ok, sec_ok, lane_ok, link_ok;

   generate
      if (NUM_CTX == IDX_SPAN) begin : g_ctx_full
         assign ctx_pad = ctx_hit;
      end else begin : g_ctx_pad
         assign ctx_pad = {{(IDX_SPAN-NUM_CTX){1'b0}}, ctx_hit};
      end
   endgenerate

   always_comb begin
      is_load  = 1'b0;
      is_store = 1'b0;
      case (acc_kind)
         KIND_LOAD:  is_load  = 1'b1;
         KIND_LDEX:  is_load  = 1'b1;
         KIND_STORE: is_store = 1'b1;
         KIND_STEX:  is_store = acc_excl_pass;
         KIND_SWAP: begin
            is_load  = 1'b1;
            is_store = 1'b1;
         end
         default: ;
      endcase
   end

   assign kind_ok   = (ctrl.kind[0] & is_load) | (ctrl.kind[1] & is_store);
   assign priv_ok   = acc_priv ? ctrl.priv[0] : ctrl.priv[1];
   assign sec_ok    = (ctrl.sec == 2'b00) ||
                      (ctrl.sec == 2'b01 && !acc_secure) ||
                      (ctrl.sec == 2'b10 &&  acc_secure);
   assign lane_ok   = |(acc_lanes & ctrl.bsel);
   assign link_flag = ctx_pad[ctrl.link_idx];
   assign link_ok   = !ctrl.link_en || link_flag;
   assign attr_ok   = ctrl.en & kind_ok & priv_ok & sec_ok & lane_ok & link_ok;

endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
   import wpt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_CTX = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               acc_valid,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [3:0]         acc_lanes,
   input  logic [2:0]         acc_kind,
   input  logic               acc_priv,
   input  logic               acc_secure,
   input  logic               acc_excl_pass,
   input  logic [NUM_CTX-1:0] ctx_hit,
   output logic               wp_hit
);

   localparam int MASK_W = 5;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("wpt_unit: ADDR_W must lie in 8..32");
      end
      if (NUM_CTX < 1 || NUM_CTX > 16) begin : g_bad_ctx
         $error("wpt_unit: NUM_CTX must lie in 1..16");
      end
   endgenerate

   wpt_ctrl_t         ctrl;
   logic [ADDR_W-1:0] watch_addr;
   logic              addr_ok, attr_ok, link_flag;
   logic              hit_q;

   wpt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .watch_addr (watch_addr),
      .ctrl       (ctrl)
   );

   wpt_addr_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_addr (
      .acc_addr   (acc_addr),
      .watch_addr (watch_addr),
      .mask       (ctrl.mask),
      .addr_ok    (addr_ok)
   );

   wpt_attr_match #(.NUM_CTX(NUM_CTX)) u_attr (
      .ctrl          (ctrl),
      .acc_lanes     (acc_lanes),
      .acc_kind      (acc_kind),
      .acc_priv      (acc_priv),
      .acc_secure    (acc_secure),
      .acc_excl_pass (acc_excl_pass),
      .ctx_hit       (ctx_hit),
      .attr_ok       (attr_ok),
      .link_flag     (link_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= acc_valid & addr_ok & attr_ok;
   end

   assign wp_hit = hit_q;

   AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(ctrl.en)) // R1
      else $error("hit while disabled");
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(acc_valid)) // R12
      else $error("hit without access");
   AST_STEX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_hit && $past(acc_kind) == KIND_STEX) |-> $past(acc_excl_pass)) // R7
      else $error("store exclusive hit without monitor pass");
   AST_LINK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_hit && $past(ctrl.link_en)) |-> $past(link_flag)) // R10
      else $error("linked hit without context match");
   AST_RSVD_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(ctrl.kind != 2'b00 && ctrl.priv != 2'b00 && ctrl.sec != 2'b11)) // R11
      else $error("hit under reserved encoding");
   AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past((acc_lanes & ctrl.bsel) != 4'b0)) // R4
      else $error("hit without selected lane");

endmodule

// File: tb/wpt_unit_bench.sv
module wpt_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [3:0]  acc_lanes = '0;
   logic [2:0]  acc_kind = '0;
   logic        acc_priv = 1'b0, acc_secure = 1'b0, acc_excl_pass = 1'b0;
   logic [15:0] ctx_hit = '0;
   logic        wp_hit;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] m_ctrl = '0, m_addr = '0;

   always #2.5 clk = ~clk;

   wpt_unit u_wpt_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_lanes(acc_lanes), .acc_kind(acc_kind),
      .acc_priv(acc_priv), .acc_secure(acc_secure), .acc_excl_pass(acc_excl_pass),
      .ctx_hit(ctx_hit), .wp_hit(wp_hit)
   );

   task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic reg_write(bit sel, logic [31:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      if (sel) m_ctrl = d & 32'h1F1F_C1FF;
      else     m_addr = d & 32'hFFFF_FFFC;
   endtask

   function automatic logic [31:0] mk_ctrl(int mask, bit link, int idx, int sec,
                                           int bsel, int kind, int priv, bit en);
      return (32'(mask) << 24) | (32'(link) << 20) | (32'(idx) << 16) | (32'(sec) << 14) |
             (32'(bsel) << 5) | (32'(kind) << 3) | (32'(priv) << 1) | 32'(en);
   endfunction

   function automatic bit ref_hit(logic [31:0] a, logic [3:0] ln, int k,
                                  bit p, bit s, bit ps, logic [15:0] cx);
      int  n;
      bit  ld, st;
      if (!m_ctrl[0]) return 0;
      n = int'(m_ctrl[28:24]);
      for (int b = 2; b < 32; b++)
         if (b >= n && a[b] != m_addr[b]) return 0;
      if ((ln & m_ctrl[8:5]) == 4'b0) return 0;
      ld = (k == 0 || k == 2 || k == 3);
      st = (k == 1 || k == 2 || (k == 4 && ps));
      case (m_ctrl[4:3])
         2'b01: if (!ld) return 0;
         2'b10: if (!st) return 0;
         2'b11: if (!(ld || st)) return 0;
         default: return 0;
      endcase
      case (m_ctrl[2:1])
         2'b01: if (!p) return 0;
         2'b10: if (p) return 0;
         2'b11: ;
         default: return 0;
      endcase
      case (m_ctrl[15:14])
         2'b00: ;
         2'b01: if (s) return 0;
         2'b10: if (!s) return 0;
         default: return 0;
      endcase
      if (m_ctrl[20] && !cx[m_ctrl[19:16]]) return 0;
      return 1;
   endfunction

   task automatic access(logic [31:0] a, logic [3:0] ln, int k, bit p, bit s,
                         bit ps, logic [15:0] cx, string tag);
      bit e;
      acc_valid = 1'b1; acc_addr = a; acc_lanes = ln; acc_kind = 3'(k);
      acc_priv = p; acc_secure = s; acc_excl_pass = ps; ctx_hit = cx;
      e = ref_hit(a, ln, k, p, s, ps, cx);
      @(posedge clk); @(negedge clk);
      acc_valid = 1'b0;
      chk(32'(wp_hit), 32'(e), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      reg_sel = 1'b0; #1 chk(reg_rdata, 32'h0, "R1 addr reset");
      reg_sel = 1'b1; #1 chk(reg_rdata, 32'h0, "R1 ctrl reset");
      chk(32'(wp_hit), 32'h0, "R1 hit reset");
      @(negedge clk);

      // R2: reserved bits
      reg_write(1'b1, 32'hFFFF_FFFF);
      reg_sel = 1'b1; #1 chk(reg_rdata, 32'h1F1F_C1FF, "R2 all ones");
      reg_write(1'b1, 32'hE0E0_3E00);
      reg_sel = 1'b1; #1 chk(reg_rdata, 32'h0, "R2 reserved only");
      @(negedge clk);

      // R3: alignment
      reg_write(1'b0, 32'h0000_1003);
      reg_sel = 1'b0; #1 chk(reg_rdata, 32'h0000_1000, "R3 readback");
      @(negedge clk);

      // R1: disabled never hits
      reg_write(1'b1, mk_ctrl(0, 0, 0, 0, 15, 3, 3, 0));
      access(32'h1000, 4'hF, 0, 1, 0, 1, 16'h0, "R1 disabled");
      reg_write(1'b1, mk_ctrl(0, 0, 0, 0, 15, 3, 3, 1));
      for (int lo = 0; lo < 4; lo++)
         access(32'h1000 | 32'(lo), 4'h1, 0, 1, 0, 1, 16'h0, "R3 low bits");

      // R12: valid gating and single-cycle pulse
      access(32'h1000, 4'hF, 1, 0, 1, 0, 16'h0, "R12 hit");
      @(posedge clk); @(negedge clk);
      chk(32'(wp_hit), 32'h0, "R12 pulse ends");
      acc_addr = 32'h1000; acc_lanes = 4'hF; acc_kind = 3'd0;
      @(posedge clk); @(negedge clk);
      chk(32'(wp_hit), 32'h0, "R12 no valid");

      // R6 R7 R8 R9 R11: filter sweep
      for (int kf = 0; kf < 4; kf++)
         for (int pf = 0; pf < 4; pf++)
            for (int sf = 0; sf < 4; sf++) begin
               reg_write(1'b1, mk_ctrl(0, 0, 0, sf, 15, kf, pf, 1));
               for (int k = 0; k < 8; k++)
                  for (int x = 0; x < 8; x++) begin
                     string tg;
                     if (kf == 0 || pf == 0 || sf == 3) tg = "R11 reserved";
                     else if (k == 4)                   tg = "R7 stex";
                     else                               tg = "R6 R8 R9 filters";
                     access(32'h1000, 4'hF, k, x[0], x[1], x[2], 16'h0, tg);
                  end
            end

      // R4: lane select sweep
      for (int bs = 0; bs < 16; bs++) begin
         reg_write(1'b1, mk_ctrl(0, 0, 0, 0, bs, 3, 3, 1));
         for (int ln = 0; ln < 16; ln++)
            access(32'h1000, 4'(ln), 2, 1, 1, 0, 16'h0, "R4 lanes");
      end

      // R5: address mask sweep
      reg_write(1'b0, 32'h1234_5678);
      for (int mi = 0; mi < 12; mi++) begin
         int n;
         n = (mi < 10) ? mi : ((mi == 10) ? 17 : 31);
         reg_write(1'b1, mk_ctrl(n, 0, 0, 0, 15, 3, 3, 1));
         access(32'h1234_5678, 4'hF, 0, 1, 0, 0, 16'h0, "R5 exact");
         for (int b = 2; b < 32; b++)
            access(32'h1234_5678 ^ (32'h1 << b), 4'hF, 0, 1, 0, 0, 16'h0, "R5 mask");
      end

      // R10: linking sweep
      reg_write(1'b0, 32'h0000_2000);
      for (int le = 0; le < 2; le++)
         for (int idx = 0; idx < 16; idx++) begin
            reg_write(1'b1, mk_ctrl(0, le[0], idx, 0, 15, 3, 3, 1));
            access(32'h2000, 4'hF, 0, 0, 0, 0, 16'h0, "R10 no flags");
            for (int j = 0; j < 16; j++)
               access(32'h2000, 4'hF, 0, 0, 0, 0, 16'h1 << j, "R10 link");
         end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule